// File: doc/BRIEF.md
# DMA Channel Interrupt Flag Unit

This unit keeps the two interrupt flags of a single DMA channel and the channel's run bit. The channel datapath sends it one-cycle event pulses. One pulse reports a completed transfer whose counter has reached zero. Four more report abort causes: a size error, a block or repeat size count stepping from 1 to 0, a source repeat-area overflow and a destination repeat-area overflow. The completion pulse always raises the transfer-end flag. Each abort cause has its own enable bit, and any enabled cause raises the single escape-end flag. Each flag drives an interrupt request through its own interrupt enable. Raising either flag stops the channel by dropping the run bit.

Software reaches the unit through a one-cycle read/write register port with two registers, a control register and a status register. A flag is cleared by reading it as 1 and then writing 0 to it. Writing the run bit to 1 also clears both flags at once. After a flag is cleared, software reloads the datapath and sets the run bit again to restart the channel.

Each flag is held by its own small state machine. The states are FL_CLEAR (flag low), FL_PEND (flag high, not yet read) and FL_ARMED (flag high and read as 1 since the last status write). The transitions are:
- set: FL_CLEAR to FL_PEND on a set event.
- read: FL_PEND to FL_ARMED on a status read.
- clear: FL_ARMED to FL_CLEAR on a status write of 0 to the bit.
- disarm: FL_ARMED to FL_PEND on a status write of 1 to the bit.
- restart: any state to FL_CLEAR when the run bit is written to 1.
- override: a set event forces FL_PEND over any clear or disarm in the same cycle.

Top module: `dma_irq_ctrl`

## Requirements
- R1: A pulse on `ev_done` sets the transfer-end flag (status bit 0 at address 1) at the next clock edge, whatever the enables and the run bit hold.
- R2: The escape-end flag (status bit 1 at address 1) is set when any abort cause is pulsed while its control enable is 1. The enables sit at control address 0: bit 3 for `ev_size_err`, bit 4 for `ev_blk_end`, bit 5 for `ev_src_ovf` and bit 6 for `ev_dst_ovf`. A cause whose enable is 0 has no effect.
- R3: `irq_end` is high exactly while the transfer-end flag and control bit 1 are both 1. `irq_esc` is high exactly while the escape-end flag and control bit 2 are both 1.
- R4: A write to control address 0 with bit 0 (run) equal to 1 sets the run bit and clears both flags at that same edge. A control write with bit 0 equal to 0 leaves the flags unchanged.
- R5: A status write of 0 to a flag bit clears that flag only if a status read since the previous status write returned the flag as 1. Otherwise the write leaves the flag set.
- R6: A status write of 1 to a flag bit never sets the flag.
- R7: An edge that sets either flag also clears the run bit, even when software writes run = 1 in the same cycle.
- R8: When a set event and a software clear (status write or run write) meet in one cycle, the flag ends up set.
- R9: Any status write cancels the read qualifier of both flags, so a later write of 0 clears nothing until the flag has been read as 1 again.
- R10: After synchronous active-low reset, both registers read 0 and both interrupt requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wdata | input | 7 | Write data |
| reg_rdata | output | 7 | Read data for the selected register, combinational |
| ev_done | input | 1 | Transfer counter reached zero and the transfer completed |
| ev_size_err | input | 1 | Transfer size error |
| ev_blk_end | input | 1 | Block/repeat size count went from 1 to 0 |
| ev_src_ovf | input | 1 | Source extended repeat area overflow |
| ev_dst_ovf | input | 1 | Destination extended repeat area overflow |
| irq_end | output | 1 | Transfer-end interrupt request |
| irq_esc | output | 1 | Escape-end interrupt request |

## Verification
A vector table pairs control settings with event patterns. It covers each abort cause alone with its enable on, a cause with only a different enable on, all five events together with one interrupt enable off, and a completion with the run bit low. These vectors separate the per-cause gating from the unconditional completion path, and the flags from their interrupt requests. Directed sequences then check the clear protocol. They write 0 without a prior read, then read and write 0, then write 1 in between, and clear one flag while keeping the other. These sequences separate a correct read qualifier from one that is missing or never reset. Last, a set event is made to collide with a status clear and with a run write, to show that setting takes priority.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
    localparam int unsigned NUM_ESC    = 4;
    localparam int unsigned CTL_RUN    = 0;
    localparam int unsigned CTL_END_IE = 1;
    localparam int unsigned CTL_ESC_IE = 2;
    localparam int unsigned CTL_EN_LSB = 3;
    localparam int unsigned REG_W      = CTL_EN_LSB + NUM_ESC;
    localparam int unsigned NUM_FLAGS  = 2;
    localparam int unsigned ST_END     = 0;
    localparam int unsigned ST_ESC     = 1;
    localparam logic        ADDR_CTRL  = 1'b0;
    localparam logic        ADDR_STAT  = 1'b1;

    typedef enum logic [1:0] {
        FL_CLEAR = 2'd0,
        FL_PEND  = 2'd1,
        FL_ARMED = 2'd2
    } flag_state_t;
endpackage

// File: rtl/dma_irq_cause.sv
module dma_irq_cause #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] cause_i,
    input  logic [N-1:0] en_i,
    output logic         hit_o
);
    logic [N-1:0] gated;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = cause_i[i] & en_i[i];
    end

    assign hit_o = |gated;
endmodule

// File: rtl/dma_irq_flag.sv
module dma_irq_flag
    import dma_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic hw_clr,
    input  logic wr_hit,
    input  logic wr_bit,
    input  logic rd_hit,
    output logic flag_o
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (set_ev) begin
            if (hw_clr || wr_hit)                  state_d = FL_PEND;
            else if (state_q == FL_CLEAR)          state_d = FL_PEND;
            else if (state_q == FL_PEND && rd_hit) state_d = FL_ARMED;
        end else if (hw_clr) begin
            state_d = FL_CLEAR;
        end else begin
            unique case (state_q)
                FL_CLEAR: state_d = FL_CLEAR;
                FL_PEND:  if (!wr_hit && rd_hit) state_d = FL_ARMED;
                FL_ARMED: if (wr_hit) state_d = wr_bit ? FL_PEND : FL_CLEAR;
                default:  state_d = FL_CLEAR;
            endcase
        end
    end

    always_comb begin
        flag_o = (state_q != FL_CLEAR);
    end

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag_o);

    p_no_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !set_ev) |=> !flag_o);

    p_clear_needs_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && state_q != FL_ARMED && !set_ev && !hw_clr) |=> $stable(flag_o));

    p_write_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (state_q != FL_ARMED));
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
    import dma_irq_pkg::*;
#(
    parameter int unsigned N = NUM_ESC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ctrl_wr,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 stop_ev,
    input  logic                 rd_sel,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic [REG_W-1:0]     rdata,
    output logic                 end_ie,
    output logic                 esc_ie,
    output logic [N-1:0]         cause_en
);
    logic run_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            end_ie   <= 1'b0;
            esc_ie   <= 1'b0;
            cause_en <= '0;
        end else begin
            if (ctrl_wr) begin
                end_ie   <= wdata[CTL_END_IE];
                esc_ie   <= wdata[CTL_ESC_IE];
                cause_en <= wdata[CTL_EN_LSB +: N];
            end
            if (stop_ev)      run_q <= 1'b0;
            else if (ctrl_wr) run_q <= wdata[CTL_RUN];
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_sel == ADDR_STAT) begin
            rdata[NUM_FLAGS-1:0] = flags;
        end else begin
            rdata[CTL_RUN]             = run_q;
            rdata[CTL_END_IE]          = end_ie;
            rdata[CTL_ESC_IE]          = esc_ie;
            rdata[CTL_EN_LSB +: N]     = cause_en;
        end
    end

    p_stop_clears_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !run_q);
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
    import dma_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             ev_done,
    input  logic             ev_size_err,
    input  logic             ev_blk_end,
    input  logic             ev_src_ovf,
    input  logic             ev_dst_ovf,
    output logic             irq_end,
    output logic             irq_esc
);
    logic                 ctrl_wr, stat_wr, stat_rd, run_start;
    logic                 esc_hit, end_ie, esc_ie;
    logic [NUM_ESC-1:0]   cause_en, causes;
    logic [NUM_FLAGS-1:0] flag_set, flags;

    assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
    assign stat_wr   = reg_wr && (reg_addr == ADDR_STAT);
    assign stat_rd   = reg_rd && !reg_wr && (reg_addr == ADDR_STAT);
    assign run_start = ctrl_wr && reg_wdata[CTL_RUN];
    assign causes    = {ev_dst_ovf, ev_src_ovf, ev_blk_end, ev_size_err};

    dma_irq_cause #(.N(NUM_ESC)) u_cause (
        .cause_i (causes),
        .en_i    (cause_en),
        .hit_o   (esc_hit)
    );

    assign flag_set[ST_END] = ev_done;
    assign flag_set[ST_ESC] = esc_hit;

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        dma_irq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_ev (flag_set[g]),
            .hw_clr (run_start),
            .wr_hit (stat_wr),
            .wr_bit (reg_wdata[g]),
            .rd_hit (stat_rd),
            .flag_o (flags[g])
        );
    end

    dma_irq_regs #(.N(NUM_ESC)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .wdata    (reg_wdata),
        .stop_ev  (|flag_set),
        .rd_sel   (reg_addr),
        .flags    (flags),
        .rdata    (reg_rdata),
        .end_ie   (end_ie),
        .esc_ie   (esc_ie),
        .cause_en (cause_en)
    );

    assign irq_end = flags[ST_END] & end_ie;
    assign irq_esc = flags[ST_ESC] & esc_ie;

    p_run_start_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_start && !(|flag_set)) |=> (flags == '0));

    p_done_sets_end_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ev_done |=> flags[ST_END]);
endmodule

// File: tb/dma_irq_ctrl_tb.sv
`timescale 1ns/1ps
module dma_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_addr = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [6:0] reg_wdata = '0;
    logic [6:0] reg_rdata;
    logic       ev_done = 0, ev_size_err = 0, ev_blk_end = 0, ev_src_ovf = 0, ev_dst_ovf = 0;
    logic       irq_end, irq_esc;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dma_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_done(ev_done),
        .ev_size_err(ev_size_err), .ev_blk_end(ev_blk_end), .ev_src_ovf(ev_src_ovf),
        .ev_dst_ovf(ev_dst_ovf), .irq_end(irq_end), .irq_esc(irq_esc)
    );

    // Vector fields: ctrl[16:10] events[9:5] (bit0 done,1 size,2 blk,3 src,4 dst)
    // expected status[4:3] expected {irq_esc,irq_end}[2:1] expected run[0]
    localparam int NV = 11;
    localparam logic [16:0] VEC [NV] = '{
        {7'h07, 5'h01, 2'b01, 2'b01, 1'b0},
        {7'h0F, 5'h02, 2'b10, 2'b10, 1'b0},
        {7'h07, 5'h02, 2'b00, 2'b00, 1'b1},
        {7'h17, 5'h04, 2'b10, 2'b10, 1'b0},
        {7'h27, 5'h08, 2'b10, 2'b10, 1'b0},
        {7'h47, 5'h10, 2'b10, 2'b10, 1'b0},
        {7'h27, 5'h10, 2'b00, 2'b00, 1'b1},
        {7'h7B, 5'h1F, 2'b11, 2'b01, 1'b0},
        {7'h03, 5'h00, 2'b00, 2'b00, 1'b1},
        {7'h01, 5'h01, 2'b01, 2'b00, 1'b0},
        {7'h00, 5'h01, 2'b01, 2'b00, 1'b0}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic rd, input logic addr,
                       input logic [6:0] wd, input logic [4:0] ev,
                       output logic [6:0] rv, output logic [1:0] iv);
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = addr; reg_wdata = wd;
        {ev_dst_ovf, ev_src_ovf, ev_blk_end, ev_size_err, ev_done} = ev;
        #1;
        rv = reg_rdata;
        iv = {irq_esc, irq_end};
        @(posedge clk);
        #1;
        reg_wr = 0; reg_rd = 0; reg_wdata = '0;
        {ev_dst_ovf, ev_src_ovf, ev_blk_end, ev_size_err, ev_done} = '0;
    endtask

    logic [6:0] rv;
    logic [1:0] iv;

    task automatic wr_ctrl(input logic [6:0] d);
        cyc(1, 0, 0, d, 5'h00, rv, iv);
    endtask
    task automatic wr_stat(input logic [6:0] d);
        cyc(1, 0, 1, d, 5'h00, rv, iv);
    endtask
    task automatic pulse(input logic [4:0] e);
        cyc(0, 0, 0, 7'h00, e, rv, iv);
    endtask
    task automatic rd(input logic a);
        cyc(0, 1, a, 7'h00, 5'h00, rv, iv);
    endtask

    initial begin
        #20000;
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state observed while still in reset, then after release
        #1;
        check("R10 ctrl in reset", {1'b0, reg_rdata}, 8'h00);
        check("R10 irqs in reset", {6'b0, irq_esc, irq_end}, 8'h00);
        rst_n = 1'b1;
        rd(1); check("R10 status", {1'b0, rv}, 8'h00);
        rd(0); check("R10 ctrl", {1'b0, rv}, 8'h00);

        // Table: R1 R2 R3 R4 R7
        for (int i = 0; i < NV; i++) begin
            wr_ctrl(VEC[i][16:10]);
            pulse(VEC[i][9:5]);
            rd(1);
            check($sformatf("R1/R2 vec%0d status", i), {1'b0, rv}, {6'b0, VEC[i][4:3]});
            check($sformatf("R3 vec%0d irq", i), {6'b0, iv}, {6'b0, VEC[i][2:1]});
            rd(0);
            check($sformatf("R7 vec%0d run", i), {7'b0, rv[0]}, {7'b0, VEC[i][0]});
        end

        // R4: run write clears pending end flag
        wr_ctrl(7'h01);
        rd(1); check("R4 run start clears", {1'b0, rv}, 8'h00);
        // R6: write 1 never sets
        wr_stat(7'h03);
        rd(1); check("R6 write one ignored", {1'b0, rv}, 8'h00);

        // R5: write 0 without read, then read-then-write-0
        pulse(5'h01);
        wr_ctrl(7'h02);
        rd(0); check("R3 irq_end raised", {6'b0, iv}, 8'h01);
        check("R4 ctrl write run=0 keeps flag", {7'b0, rv[0]}, 8'h00);
        wr_stat(7'h00);
        rd(1); check("R5 no clear without read", {1'b0, rv}, 8'h01);
        wr_stat(7'h00);
        rd(1); check("R5 read then write 0 clears", {1'b0, rv}, 8'h00);
        check("R3 irq_end dropped", {6'b0, iv}, 8'h00);

        // R5 R6 per flag
        wr_ctrl(7'h0F);
        pulse(5'h03);
        rd(1); check("R1/R2 both flags", {1'b0, rv}, 8'h03);
        wr_stat(7'h02);
        rd(1); check("R5 clear end keep esc", {1'b0, rv}, 8'h02);
        wr_stat(7'h00);
        rd(1); check("R5 clear esc", {1'b0, rv}, 8'h00);

        // R9: a write cancels the qualifier
        wr_ctrl(7'h09);
        pulse(5'h02);
        rd(1);
        wr_stat(7'h02);
        wr_stat(7'h00);
        rd(1); check("R9 qualifier reset by write", {1'b0, rv}, 8'h02);

        // R8: set event with clearing status write in one cycle (flag armed by read above)
        cyc(1, 0, 1, 7'h00, 5'h02, rv, iv);
        rd(1); check("R8 set beats status clear", {1'b0, rv}, 8'h02);

        // R7 R8: run write colliding with set event
        cyc(1, 0, 0, 7'h09, 5'h02, rv, iv);
        rd(1); check("R8 set beats run clear", {1'b0, rv}, 8'h02);
        rd(0); check("R7 run stays low", {1'b0, rv}, 8'h08);

        // R4 then R2 disabled causes
        wr_ctrl(7'h09);
        rd(1); check("R4 flags cleared", {1'b0, rv}, 8'h00);
        rd(0); check("R4 run set", {1'b0, rv}, 8'h09);
        pulse(5'h1C);
        rd(1); check("R2 disabled causes ignored", {1'b0, rv}, 8'h00);
        rd(0); check("R2 run kept", {7'b0, rv[0]}, 8'h01);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule